// File: doc/BRIEF.md
# Protected Half-Bridge Gate Controller

This block drives the gates of three half-bridge legs. Each leg has a high-side switch and a low-side switch. A control word sets a static on-request for every switch. A per-switch select bit can hand that switch to a shared external PWM input instead.

Protection sits between the requests and the gates:
- A software inhibit blanks every gate but keeps all requests and fault state.
- A leg asked to turn on both sides at once sets a sticky overload flag.
- Overcurrent and overtemperature flags from the analog front end pass through a synchronizer. They then disable the affected switch, and only that switch.
- Disabled switches and the overload flag stay latched until a one-clock clear pulse. That pulse comes from the rising edge of a reset-request bit.

A per-leg interlock keeps both switches of a leg from conducting together. It also inserts a fixed dead time whenever a leg hands over from one side to the other.

All pins are plain control and status levels. No stream data enters or leaves the block, so it has no valid/ready handshake. Requests are level inputs sampled every clock. Status is a level output.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, all gates are low, `overload` is 0, no switch is disabled, and `sw_status` equals the requests, which are 0.
- R2: A static request for exactly one side of a leg in the OFF state turns that side's gate on after one clock edge. The other gate stays low.
- R3: When a switch's PWM select bit is 1, its gate follows `pwm_in` with one clock edge of latency, and its static request bit is ignored.
- R4: If a leg asks for both sides on at once, neither of its gates turns on. `overload` rises after one edge and stays 1 until a clear pulse.
- R5: With `trip_mode`=0, a synchronized overcurrent flag disables its switch. With `trip_mode`=1, overcurrent flags are ignored.
- R6: An overtemperature flag disables its own switch in either mode, and no other switch. Flag and status bit index i maps to leg i high side for i<3 and to leg i-3 low side for i>=3. The status bit falls exactly three edges after the flag is applied: two synchronizer flops and the latch. The gate falls one edge later.
- R7: A disabled switch stays off, with its `sw_status` bit low, after its fault flag clears. It recovers only through a clear pulse.
- R8: A 0-to-1 change of `reset_req` produces one clear pulse. Two edges later, `overload` and all disables are 0. Holding `reset_req` at 1 produces no further pulse.
- R9: While `inhibit` is 1, all gates go low one edge later, and `sw_status` is unchanged. Dropping `inhibit` restores the requested gates one edge later.
- R10: The two gates of a leg are never high together. When a leg changes from one side to the other, both gates are low for exactly DEAD_CYCLES cycles before the new side turns on.
- R11: A side that is released and requested again, with the opposite side never requested, turns back on one edge later with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 3 | Static high-side on-request, one bit per leg |
| ls_req | input | 3 | Static low-side on-request, one bit per leg |
| pwm_sel_hs | input | 3 | High-side switch follows `pwm_in` when 1 |
| pwm_sel_ls | input | 3 | Low-side switch follows `pwm_in` when 1 |
| pwm_in | input | 1 | External PWM level |
| inhibit | input | 1 | Software inhibit; blanks all gates |
| trip_mode | input | 1 | 0: overcurrent trips a switch, 1: only overtemperature trips |
| reset_req | input | 1 | Reset-request level; its rising edge clears faults |
| oc_flag | input | 6 | Raw overcurrent flags, [2:0] high sides, [5:3] low sides |
| ot_flag | input | 6 | Raw overtemperature flags, same order |
| gate_hs | output | 3 | High-side gate drive per leg |
| gate_ls | output | 3 | Low-side gate drive per leg |
| overload | output | 1 | Latched short/overload flag |
| sw_status | output | 6 | Request AND not disabled, same order as flags |

## Verification
The bench builds the block with DEAD_CYCLES=5 and keeps three legs. Five is longer than the three-edge fault latency, so a dead-time window cannot be confused with the fault latency. It also keeps each side-to-side handover short enough to check every idle cycle one by one. With three legs, a fault on one leg can be tested against outputs that must stay on in another leg. The default synchronizer depth of two is kept, so the exact three-edge status latency is checked.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    LEG_OFF,
    LEG_HI,
    LEG_LO,
    LEG_GAP_HI,
    LEG_GAP_LO
  } leg_state_e;
endpackage

// File: rtl/hb_flag_sync.sv
module hb_flag_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
  parameter int NOUT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOUT-1:0] oc_s,
  input  logic [NOUT-1:0] ot_s,
  input  logic            trip_mode,
  input  logic            short_any,
  input  logic            reset_req,
  output logic [NOUT-1:0] disabled,
  output logic            ovl,
  output logic            clr_pulse
);
  logic            req_q;
  logic [NOUT-1:0] trip;

  assign trip = ot_s | (trip_mode ? '0 : oc_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      clr_pulse <= 1'b0;
      disabled  <= '0;
      ovl       <= 1'b0;
    end else begin
      req_q     <= reset_req;
      clr_pulse <= reset_req & ~req_q;
      disabled  <= clr_pulse ? '0 : (disabled | trip);
      ovl       <= clr_pulse ? 1'b0 : (ovl | short_any);
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (!ovl && disabled == '0));
  // R4
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl && !clr_pulse) |=> ovl);
  // R7
  dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> ((disabled & $past(disabled)) == $past(disabled)));
endmodule

// File: rtl/hb_leg_interlock.sv
module hb_leg_interlock
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CYCLES - 1);

  leg_state_e state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic only_hi, only_lo;

  assign only_hi = want_hi & ~want_lo;
  assign only_lo = want_lo & ~want_hi;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      LEG_OFF: begin
        if (only_hi)      state_n = LEG_HI;
        else if (only_lo) state_n = LEG_LO;
      end
      LEG_HI: begin
        if (!want_hi) begin
          state_n = LEG_GAP_HI;
          cnt_n   = GAP_LOAD;
        end
      end
      LEG_LO: begin
        if (!want_lo) begin
          state_n = LEG_GAP_LO;
          cnt_n   = GAP_LOAD;
        end
      end
      LEG_GAP_HI: begin
        if (only_hi) state_n = LEG_HI;
        else if (cnt == '0) begin
          if (only_lo)                  state_n = LEG_LO;
          else if (!want_hi && !want_lo) state_n = LEG_OFF;
        end else cnt_n = cnt - 1'b1;
      end
      LEG_GAP_LO: begin
        if (only_lo) state_n = LEG_LO;
        else if (cnt == '0) begin
          if (only_hi)                  state_n = LEG_HI;
          else if (!want_hi && !want_lo) state_n = LEG_OFF;
        end else cnt_n = cnt - 1'b1;
      end
      default: state_n = LEG_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= LEG_OFF;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  assign gate_hi = (state == LEG_HI);
  assign gate_lo = (state == LEG_LO);

  // Checker state: idle run length and last conducting side
  logic [CW-1:0] idle_run;
  logic          last_hi, last_lo;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= '0;
      last_hi  <= 1'b0;
      last_lo  <= 1'b0;
    end else begin
      if (gate_hi || gate_lo)          idle_run <= '0;
      else if (idle_run != CW'(DEAD_CYCLES)) idle_run <= idle_run + 1'b1;
      if (gate_hi) begin last_hi <= 1'b1; last_lo <= 1'b0; end
      if (gate_lo) begin last_lo <= 1'b1; last_hi <= 1'b0; end
    end
  end

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R10
  gap_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo) && last_hi) |-> (idle_run >= CW'(DEAD_CYCLES)));
  // R10
  gap_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && last_lo) |-> (idle_run >= CW'(DEAD_CYCLES)));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int NLEGS       = 3,
  parameter int DEAD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NLEGS-1:0]   hs_req,
  input  logic [NLEGS-1:0]   ls_req,
  input  logic [NLEGS-1:0]   pwm_sel_hs,
  input  logic [NLEGS-1:0]   pwm_sel_ls,
  input  logic               pwm_in,
  input  logic               inhibit,
  input  logic               trip_mode,
  input  logic               reset_req,
  input  logic [2*NLEGS-1:0] oc_flag,
  input  logic [2*NLEGS-1:0] ot_flag,
  output logic [NLEGS-1:0]   gate_hs,
  output logic [NLEGS-1:0]   gate_ls,
  output logic               overload,
  output logic [2*NLEGS-1:0] sw_status
);
  localparam int NOUT = 2 * NLEGS;

  logic [NOUT-1:0]  oc_s, ot_s, disabled;
  logic [NLEGS-1:0] dem_hs, dem_ls;
  logic             clr_pulse;

  hb_flag_sync #(.WIDTH(NOUT), .STAGES(SYNC_STAGES)) u_oc_sync (
    .clk(clk), .rst_n(rst_n), .d_in(oc_flag), .d_out(oc_s));
  hb_flag_sync #(.WIDTH(NOUT), .STAGES(SYNC_STAGES)) u_ot_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ot_flag), .d_out(ot_s));

  for (genvar i = 0; i < NLEGS; i++) begin : g_dem
    assign dem_hs[i] = pwm_sel_hs[i] ? pwm_in : hs_req[i];
    assign dem_ls[i] = pwm_sel_ls[i] ? pwm_in : ls_req[i];
  end

  hb_fault_latch #(.NOUT(NOUT)) u_fault (
    .clk(clk), .rst_n(rst_n), .oc_s(oc_s), .ot_s(ot_s),
    .trip_mode(trip_mode), .short_any(|(dem_hs & dem_ls)),
    .reset_req(reset_req), .disabled(disabled), .ovl(overload),
    .clr_pulse(clr_pulse));

  for (genvar i = 0; i < NLEGS; i++) begin : g_leg
    hb_leg_interlock #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .want_hi(dem_hs[i] & ~disabled[i] & ~inhibit),
      .want_lo(dem_ls[i] & ~disabled[NLEGS+i] & ~inhibit),
      .gate_hi(gate_hs[i]), .gate_lo(gate_ls[i]));
  end

  assign sw_status = {ls_req, hs_req} & ~disabled;

  // R9
  inhibit_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (gate_hs == '0 && gate_ls == '0));
  // R6
  disabled_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disabled != '0) |-> (({gate_ls, gate_hs} & $past(disabled)) == '0));
endmodule

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int DC = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NL-1:0] hs_req, ls_req, pwm_sel_hs, pwm_sel_ls;
  logic pwm_in, inhibit, trip_mode, reset_req;
  logic [2*NL-1:0] oc_flag, ot_flag;
  logic [NL-1:0] gate_hs, gate_ls;
  logic overload;
  logic [2*NL-1:0] sw_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_gate_ctrl #(.NLEGS(NL), .DEAD_CYCLES(DC), .SYNC_STAGES(2)) u_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .pwm_sel_hs(pwm_sel_hs), .pwm_sel_ls(pwm_sel_ls), .pwm_in(pwm_in),
    .inhibit(inhibit), .trip_mode(trip_mode), .reset_req(reset_req),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .gate_hs(gate_hs),
    .gate_ls(gate_ls), .overload(overload), .sw_status(sw_status));

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    hs_req = '0; ls_req = '0; pwm_sel_hs = '0; pwm_sel_ls = '0; pwm_in = 0;
    tick(DC + 2);
  endtask

  task automatic pulse_clear();
    reset_req = 1'b0; tick();
    reset_req = 1'b1; tick(2);
    reset_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 gates", {gate_ls, gate_hs}, 0);
    check("R1 overload", overload, 0);
    check("R1 status", sw_status, 0);
  endtask

  task automatic t_static();
    hs_req[0] = 1'b1; tick();
    check("R2 hs on", {gate_ls, gate_hs}, 6'b000001);
    hs_req[0] = 1'b0; tick();
    check("R11 released", gate_hs, 0);
    hs_req[0] = 1'b1; tick();
    check("R11 same-side return", gate_hs, 3'b001);
    settle();
  endtask

  task automatic t_swap();
    hs_req[2] = 1'b1; tick();
    check("R2 leg2 hs", gate_hs[2], 1);
    hs_req[2] = 1'b0; ls_req[2] = 1'b1;
    for (int k = 1; k <= DC; k++) begin
      tick();
      check("R10 gap both low", {gate_hs[2], gate_ls[2]}, 0);
    end
    tick();
    check("R10 new side on", {gate_hs[2], gate_ls[2]}, 2'b01);
    settle();
  endtask

  task automatic t_pwm();
    logic [7:0] pat = 8'b0100_1011;
    pwm_sel_hs[1] = 1'b1; hs_req[1] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      pwm_in = pat[k]; tick();
      check("R3 pwm follow", gate_hs[1], {31'b0, pat[k]});
    end
    settle();
  endtask

  task automatic t_inhibit();
    hs_req[0] = 1'b1; ls_req[2] = 1'b1; tick();
    inhibit = 1'b1; tick();
    check("R9 blanked", {gate_ls, gate_hs}, 0);
    check("R9 status kept", sw_status, 6'b100001);
    inhibit = 1'b0; tick();
    check("R9 resumed", {gate_ls, gate_hs}, 6'b100001);
    settle();
  endtask

  task automatic t_short();
    hs_req[1] = 1'b1; ls_req[1] = 1'b1; tick();
    check("R4 overload set", overload, 1);
    check("R4 no gate", {gate_hs[1], gate_ls[1]}, 0);
    hs_req[1] = 1'b0; ls_req[1] = 1'b0; tick(5);
    check("R4 overload held", overload, 1);
  endtask

  task automatic t_oc_and_clear();
    trip_mode = 1'b1; hs_req[0] = 1'b1; tick();
    oc_flag[0] = 1'b1; tick(6);
    check("R5 oc ignored gate", gate_hs[0], 1);
    check("R5 oc ignored status", sw_status[0], 1);
    trip_mode = 1'b0; tick();
    check("R5 oc trips status", sw_status[0], 0);
    tick();
    check("R5 oc trips gate", gate_hs[0], 0);
    oc_flag[0] = 1'b0; tick(4);
    check("R7 still disabled", sw_status[0], 0);
    check("R7 gate still off", gate_hs[0], 0);
    reset_req = 1'b1; tick(2);
    check("R8 cleared status", sw_status[0], 1);
    check("R8 cleared overload", overload, 0);
    oc_flag[0] = 1'b1; tick(5);
    oc_flag[0] = 1'b0; tick(4);
    check("R8 held req no repulse", sw_status[0], 0);
    reset_req = 1'b0; tick();
    reset_req = 1'b1; tick(2);
    check("R8 new pulse clears", sw_status[0], 1);
    tick();
    check("R8 gate back", gate_hs[0], 1);
    reset_req = 1'b0;
    settle();
  endtask

  task automatic t_ot();
    trip_mode = 1'b1; hs_req[0] = 1'b1; ls_req[2] = 1'b1; tick();
    ot_flag[0] = 1'b1; tick(2);
    check("R6 not early", sw_status[0], 1);
    tick();
    check("R6 status low", sw_status[0], 0);
    tick();
    check("R6 gate off", gate_hs[0], 0);
    check("R6 other leg kept", gate_ls[2], 1);
    check("R6 other status", sw_status[5], 1);
    ot_flag[0] = 1'b0; tick(4);
    check("R7 ot latched", sw_status[0], 0);
    pulse_clear(); tick();
    check("R8 ot cleared", gate_hs[0], 1);
    settle();
  endtask

  initial begin
    rst_n = 1'b0; hs_req = '0; ls_req = '0; pwm_sel_hs = '0; pwm_sel_ls = '0;
    pwm_in = 0; inhibit = 0; trip_mode = 0; reset_req = 0; oc_flag = '0; ot_flag = '0;
    tick(3);
    rst_n = 1'b1; tick();
    t_reset();
    t_static();
    t_swap();
    t_pwm();
    t_inhibit();
    t_short();
    t_oc_and_clear();
    t_ot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule